// File: doc/BRIEF.md
# SDRAM Command Issue Engine

This block turns single software command writes into SDRAM bus commands for up to two chip-select banks. Software writes a 32-bit command word. The word selects an operation, the banks it applies to, a repeat count for auto-refresh and a mode-register value. The engine drives the command on the SDRAM control pins for one clock. It then holds a busy flag for the wait that the timing register gives for that operation. Software polls the busy flag between steps. The usual bring-up order is clock enable, precharge of all rows, a burst of auto-refreshes, the mode-register load, and finally normal mode.

Once a bank has been put in normal mode, an internal down-counter reloads from the programmed refresh count. Each time the counter expires, the engine sends one auto-refresh to every bank in normal mode. A refresh that falls due while another command is still in progress is held back and issued as soon as the engine is idle again. Command writes that arrive while busy is set are dropped.

Top module: `sdram_cmd_engine`

## Requirements
- R1: While reset is held and right after it is released, the status word is zero. CKE is low, both chip selects are high, RAS_n, CAS_n and WE_n are high, and the address bus is zero.
- R2: A command is driven for exactly one cycle, and in every other cycle RAS_n, CAS_n and WE_n are all high. Each command has its own pin pattern:
  - Precharge-all (mode code 2): RAS_n low, CAS_n high, WE_n low, with address bit 10 high and all other address bits low.
  - Auto-refresh (code 3): RAS_n low, CAS_n low, WE_n high, address zero.
  - Load mode (code 4): all three strobes low.
  - Self-refresh (code 5): the auto-refresh pattern, in the same cycle that CKE goes low.
- R3: The mode code is command bits [2:0]. Command bit 4 selects bank 1, which drives cs_n[0] low. Command bit 3 selects bank 2, which drives cs_n[1] low. A command with neither bit set asserts no chip select but still runs its full wait.
- R4: Status bit 5 is busy, and every other status bit reads zero. Busy rises in the cycle after an accepted write and stays high for W+1 cycles. W is 0 for clock start (code 1), power-down (code 6) and code 7, TRP for precharge, TRC for each auto-refresh, TMRD for load mode, TRAS for self-refresh and TXSR for normal mode (code 0).
- R5: Command bits [8:5] give the auto-refresh repeat count N. An auto-refresh command issues N+1 refreshes, TRC+1 cycles apart, and busy lasts (N+1)*(TRC+1) cycles.
- R6: During a load-mode command, the address bus carries command bits [9+ADDR_W-1:9]. This value holds burst length from its bit 0 and CAS latency from its bit 4.
- R7: Clock start and normal mode drive CKE high. Self-refresh and power-down drive it low. Every other command leaves CKE unchanged.
- R8: A command write that arrives while busy is high has no effect. It produces no bus command, does not change CKE, and does not lengthen busy.
- R9: The timing register fields are TMRD [3:0], TXSR [7:4], TRAS [11:8], TRC [15:12], TWR [19:16], TRP [23:20] and TRCD [27:24]. TWR and TRCD are stored, but no command in this block waits on them.
- R10: The refresh count is refresh-register bits [REF_W:1]. A normal-mode command enables refresh for the banks it targets. Self-refresh and power-down disable refresh for the banks they target. While at least one bank is enabled, one auto-refresh goes to all enabled banks at each expiry. Expiries are count+1 cycles apart, and the first comes count+1 cycles after the enabling command is accepted. With no bank enabled, no periodic refresh is issued.
- R11: A refresh expiry that occurs while busy is high is kept pending. The refresh is issued in the cycle after busy falls. A software write in the same idle cycle as a refresh expiry wins, and the refresh follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| tim_wr | input | 1 | Timing register write strobe |
| tim_wdata | input | 32 | Timing register value |
| rfr_wr | input | 1 | Refresh register write strobe |
| rfr_wdata | input | 32 | Refresh register value (count from bit 1) |
| stat_rdata | output | 32 | Status word, busy at bit 5 |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, index 0 is bank 1 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | ADDR_W | SDRAM address bus |

## Verification
The hardest case to reach from the ports is a refresh expiry that lands while a software command is still busy, because the pending refresh must come out in the cycle after busy falls. The stimulus sets a 41-cycle refresh period and enables both banks with a normal-mode command. It then starts a two-refresh software burst, timed to the clock edge, so that its busy window spans the first expiry. The scoreboard expects the deferred refresh seven cycles after the last software refresh, and the next periodic one 31 cycles after that. A second hard case is a command write during busy. It is driven on the cycle after a precharge is accepted, and the bench checks that no extra bus command appears and that busy does not get longer.

// File: rtl/sdram_cmd_pkg.sv
// Shared types and field positions for the SDRAM command issue engine.
// Assumes exactly two chip-select banks, selected by two command bits.
package sdram_cmd_pkg;

    localparam int NUM_CS        = 2;
    localparam int TIM_FIELD_W   = 4;
    localparam int CMD_MODE_LSB  = 0;
    localparam int CMD_TGT2_BIT  = 3;
    localparam int CMD_TGT1_BIT  = 4;
    localparam int CMD_REP_LSB   = 5;
    localparam int CMD_REP_W     = 4;
    localparam int CMD_PAY_LSB   = 9;
    localparam int STAT_BUSY_BIT = 5;

    typedef enum logic [2:0] {
        MODE_NORMAL   = 3'd0,
        MODE_CLK_ON   = 3'd1,
        MODE_PRE_ALL  = 3'd2,
        MODE_AREF     = 3'd3,
        MODE_LOAD_MR  = 3'd4,
        MODE_SELF_REF = 3'd5,
        MODE_PWR_DOWN = 3'd6,
        MODE_RSVD     = 3'd7
    } sd_mode_e;

    // Strobe triple, order ras_n, cas_n, we_n.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    localparam sd_pins_t PINS_NOP  = 3'b111;
    localparam sd_pins_t PINS_PRE  = 3'b010;
    localparam sd_pins_t PINS_AREF = 3'b001;
    localparam sd_pins_t PINS_LMR  = 3'b000;

    // Timing register image, bits [27:0]; tmrd sits in the low nibble.
    typedef struct packed {
        logic [TIM_FIELD_W-1:0] trcd;
        logic [TIM_FIELD_W-1:0] trp;
        logic [TIM_FIELD_W-1:0] twr;
        logic [TIM_FIELD_W-1:0] trc;
        logic [TIM_FIELD_W-1:0] tras;
        logic [TIM_FIELD_W-1:0] txsr;
        logic [TIM_FIELD_W-1:0] tmrd;
    } sd_timing_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: maps a mode code to its pin pattern, its wait count
// and its effect on CKE. Purely combinational; assumes the timing image
// is already registered.
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
(
    input  sd_mode_e               mode,
    input  sd_timing_t             tim,
    output logic [TIM_FIELD_W-1:0] wait_cnt,
    output sd_pins_t               pins,
    output logic                   issue,
    output logic                   cke_set,
    output logic                   cke_clr
);

    logic unused_tim;
    assign unused_tim = ^{tim.twr, tim.trcd};

    // Per-mode table of wait, strobes and CKE action.
    always_comb begin
        wait_cnt = '0;
        pins     = PINS_NOP;
        issue    = 1'b0;
        cke_set  = 1'b0;
        cke_clr  = 1'b0;
        case (mode)
            MODE_NORMAL: begin
                wait_cnt = tim.txsr;
                cke_set  = 1'b1;
            end
            MODE_CLK_ON: cke_set = 1'b1;
            MODE_PRE_ALL: begin
                wait_cnt = tim.trp;
                pins     = PINS_PRE;
                issue    = 1'b1;
            end
            MODE_AREF: begin
                wait_cnt = tim.trc;
                pins     = PINS_AREF;
                issue    = 1'b1;
            end
            MODE_LOAD_MR: begin
                wait_cnt = tim.tmrd;
                pins     = PINS_LMR;
                issue    = 1'b1;
            end
            MODE_SELF_REF: begin
                wait_cnt = tim.tras;
                pins     = PINS_AREF;
                issue    = 1'b1;
                cke_clr  = 1'b1;
            end
            MODE_PWR_DOWN: cke_clr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
// Refresh interval counter: while run is high it counts down from the
// reload value and pulses tick for one cycle when it reaches zero, then
// reloads. While run is low it stays preloaded, so the first tick comes
// reload+1 cycles after run rises.
module sdram_refresh_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    // Down-count while running, reload on expiry or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (!run || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_reload_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == '0) |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/sdram_cmd_seq.sv
// Command sequencer: accepts a command word when idle, drives it on the
// pins for one cycle, holds busy for the decoded wait, repeats auto-refresh
// as requested and inserts timer refreshes for banks in normal mode.
// Assumes ADDR_W is at least 11 (A10) and at most 23 (payload width).
module sdram_cmd_seq
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  sd_timing_t        tim,
    input  logic              ref_tick,
    output logic              busy,
    output logic              cke,
    output logic [NUM_CS-1:0] cs_n,
    output sd_pins_t          pins,
    output logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] en_mask
);

    localparam int A10 = 10;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_st_e;

    seq_st_e                st_q;
    sd_mode_e               cur_mode;
    logic [NUM_CS-1:0]      cur_tgt;
    logic [CMD_REP_W-1:0]   rep_q;
    logic [TIM_FIELD_W-1:0] cnt_q;
    logic                   pend_q;

    sd_mode_e               wr_mode;
    logic [NUM_CS-1:0]      wr_tgt;
    logic [CMD_REP_W-1:0]   wr_rep;
    logic [ADDR_W-1:0]      wr_pay;
    logic [ADDR_W-1:0]      pre_addr;
    logic                   accept;
    sd_mode_e               dec_mode;
    logic [TIM_FIELD_W-1:0] dec_wait;
    sd_pins_t               dec_pins;
    logic                   dec_issue;
    logic                   dec_cke_set;
    logic                   dec_cke_clr;
    logic                   unused_cmd;

    assign wr_mode    = sd_mode_e'(cmd_wdata[CMD_MODE_LSB +: 3]);
    assign wr_tgt     = {cmd_wdata[CMD_TGT2_BIT], cmd_wdata[CMD_TGT1_BIT]};
    assign wr_rep     = cmd_wdata[CMD_REP_LSB +: CMD_REP_W];
    assign wr_pay     = cmd_wdata[CMD_PAY_LSB +: ADDR_W];
    assign unused_cmd = ^cmd_wdata[31:CMD_PAY_LSB+ADDR_W];
    assign accept     = (st_q == ST_IDLE) && cmd_wr;
    assign dec_mode   = accept ? wr_mode : MODE_AREF;

    // Address pattern for precharge-all: only A10 set.
    always_comb begin
        pre_addr      = '0;
        pre_addr[A10] = 1'b1;
    end

    sdram_cmd_decode u_decode (
        .mode     (dec_mode),
        .tim      (tim),
        .wait_cnt (dec_wait),
        .pins     (dec_pins),
        .issue    (dec_issue),
        .cke_set  (dec_cke_set),
        .cke_clr  (dec_cke_clr)
    );

    // Sequencer state, pin registers, CKE, bank enables and pending refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_mode <= MODE_NORMAL;
            cur_tgt  <= '0;
            rep_q    <= '0;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            busy     <= 1'b0;
            cke      <= 1'b0;
            cs_n     <= '1;
            pins     <= PINS_NOP;
            addr     <= '0;
            en_mask  <= '0;
        end else begin
            cs_n <= '1;
            pins <= PINS_NOP;
            addr <= '0;
            if (ref_tick) pend_q <= 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_mode <= wr_mode;
                        cur_tgt  <= wr_tgt;
                        rep_q    <= (wr_mode == MODE_AREF) ? wr_rep : '0;
                        cnt_q    <= dec_wait;
                        busy     <= 1'b1;
                        st_q     <= ST_WAIT;
                        if (dec_issue) begin
                            pins <= dec_pins;
                            cs_n <= ~wr_tgt;
                            if (wr_mode == MODE_PRE_ALL) addr <= pre_addr;
                            if (wr_mode == MODE_LOAD_MR) addr <= wr_pay;
                        end
                        if (dec_cke_set) cke <= 1'b1;
                        if (dec_cke_clr) cke <= 1'b0;
                        if (wr_mode == MODE_NORMAL) en_mask <= en_mask | wr_tgt;
                        if (wr_mode == MODE_SELF_REF || wr_mode == MODE_PWR_DOWN)
                            en_mask <= en_mask & ~wr_tgt;
                    end else if ((pend_q || ref_tick) && en_mask != '0) begin
                        cur_mode <= MODE_AREF;
                        cur_tgt  <= en_mask;
                        rep_q    <= '0;
                        cnt_q    <= dec_wait;
                        busy     <= 1'b1;
                        st_q     <= ST_WAIT;
                        pins     <= PINS_AREF;
                        cs_n     <= ~en_mask;
                        pend_q   <= 1'b0;
                    end else if (en_mask == '0) begin
                        pend_q <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (rep_q != '0) begin
                        rep_q <= rep_q - 1'b1;
                        cnt_q <= dec_wait;
                        pins  <= PINS_AREF;
                        cs_n  <= ~cur_tgt;
                    end else begin
                        busy <= 1'b0;
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assert_busy_covers_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> busy);

    assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(cur_mode) && $stable(cur_tgt) && $stable(cke)));

    assert_clk_start_cke_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_mode == MODE_CLK_ON) |=> cke);

    assert_repeat_only_aref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_q != '0) |-> (cur_mode == MODE_AREF));

    assert_precharge_a10_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_PRE && cs_n != '1) |-> addr[A10]);

endmodule

// File: rtl/sdram_cmd_engine.sv
// Top level of the SDRAM command issue engine: holds the timing and
// refresh registers, runs the refresh timer while any bank is in normal
// mode and drives the SDRAM control pins from the sequencer.
// Assumes the write strobes are single-cycle and synchronous to clk.
module sdram_cmd_engine
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int REF_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  logic              tim_wr,
    input  logic [31:0]       tim_wdata,
    input  logic              rfr_wr,
    input  logic [31:0]       rfr_wdata,
    output logic [31:0]       stat_rdata,
    output logic              sd_cke,
    output logic [1:0]        sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr
);

    localparam int TIM_W = $bits(sd_timing_t);

    sd_timing_t        tim_q;
    logic [REF_W-1:0]  rfr_q;
    logic              ref_tick;
    logic              busy;
    sd_pins_t          pins;
    logic [NUM_CS-1:0] en_mask;
    logic              unused_bits;

    assign unused_bits = ^{tim_wdata[31:TIM_W], rfr_wdata[0], rfr_wdata[31:REF_W+1]};

    // Software-written timing and refresh-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q <= '0;
            rfr_q <= '1;
        end else begin
            if (tim_wr) tim_q <= sd_timing_t'(tim_wdata[TIM_W-1:0]);
            if (rfr_wr) rfr_q <= rfr_wdata[1 +: REF_W];
        end
    end

    sdram_refresh_timer #(.CNT_W(REF_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_mask != '0),
        .reload (rfr_q),
        .tick   (ref_tick)
    );

    sdram_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .tim       (tim_q),
        .ref_tick  (ref_tick),
        .busy      (busy),
        .cke       (sd_cke),
        .cs_n      (sd_cs_n),
        .pins      (pins),
        .addr      (sd_addr),
        .en_mask   (en_mask)
    );

    // Status word: busy flag only.
    always_comb begin
        stat_rdata                = '0;
        stat_rdata[STAT_BUSY_BIT] = busy;
    end

    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    assert_no_refresh_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !ref_tick);

endmodule

// File: tb/sdram_cmd_engine_bench.sv
module sdram_cmd_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        tim_wr = 1'b0;
    logic [31:0] tim_wdata = '0;
    logic        rfr_wr = 1'b0;
    logic [31:0] rfr_wdata = '0;
    logic [31:0] stat_rdata;
    logic        sd_cke;
    logic [1:0]  sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;

    sdram_cmd_engine u_sdram_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .tim_wr(tim_wr), .tim_wdata(tim_wdata), .rfr_wr(rfr_wr), .rfr_wdata(rfr_wdata),
        .stat_rdata(stat_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [1:0]  cs_n;
        logic [2:0]  rcw;
        logic [12:0] addr;
        logic        cke;
        int          gap;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_unexp = 0;
    int   cyc = 0;
    int   last_cmd = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] cs, input logic [2:0] rcw,
                        input logic [12:0] a, input logic k, input int gap);
        exp_t x;
        x.cs_n = cs; x.rcw = rcw; x.addr = a; x.cke = k; x.gap = gap;
        q.push_back(x);
    endtask

    // Monitor: pops the expected command for every cycle with a chip select low.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sd_cs_n != 2'b11) begin
            if (q.size() == 0) begin
                n_unexp++;
                chk(1'b0, "R3", "unexpected bus command cs_n", 32'(sd_cs_n), 32'h3);
            end else begin
                e = q.pop_front();
                chk(sd_cs_n == e.cs_n, "R3", "chip selects", 32'(sd_cs_n), 32'(e.cs_n));
                chk({sd_ras_n, sd_cas_n, sd_we_n} == e.rcw, "R2", "strobes",
                    32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'(e.rcw));
                chk(sd_addr == e.addr, "R6", "address", 32'(sd_addr), 32'(e.addr));
                chk(sd_cke == e.cke, "R7", "cke with command", 32'(sd_cke), 32'(e.cke));
                if (e.gap >= 0)
                    chk(cyc - last_cmd == e.gap, "R5/R10", "command spacing",
                        32'(cyc - last_cmd), 32'(e.gap));
            end
            last_cmd = cyc;
        end
    end

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_wdata = '0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (stat_rdata[5]) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [31:0] w, input int exp_busy, input string req);
        int n;
        send(w);
        busy_len(n);
        chk(n == exp_busy, req, "busy cycles", 32'(n), 32'(exp_busy));
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(stat_rdata == 32'h0, "R1", "status in reset", stat_rdata, 32'h0);
        chk({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 6'b011111, "R1", "pins in reset",
            32'({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h1f);
        chk(sd_addr == '0, "R1", "address in reset", 32'(sd_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_rdata == 32'h0 && sd_cke == 1'b0, "R1", "after release",
            {stat_rdata[31:1], sd_cke}, 32'h0);

        // R9 timing: tmrd2 txsr3 tras4 trc5 twr1 trp3 trcd2; refresh count 40
        tim_wr = 1'b1; tim_wdata = 32'h0231_5432;
        rfr_wr = 1'b1; rfr_wdata = 32'd40 << 1;
        @(negedge clk);
        tim_wr = 1'b0; rfr_wr = 1'b0;

        // R4/R7: clock start bank 1, no bus command, one busy cycle
        run_cmd(32'h11, 1, "R4");
        chk(sd_cke == 1'b1, "R7", "cke after clock start", 32'(sd_cke), 32'h1);

        // R2/R9: precharge-all bank 1, wait TRP+1
        push(2'b10, 3'b010, 13'h400, 1'b1, -1);
        run_cmd(32'h12, 4, "R9");

        // R5: auto-refresh N=3 to bank 1
        push(2'b10, 3'b001, 13'h0, 1'b1, -1);
        for (int i = 0; i < 3; i++) push(2'b10, 3'b001, 13'h0, 1'b1, 6);
        run_cmd(32'h73, 24, "R5");
        chk(q.size() == 0, "R5", "refreshes issued", 32'(q.size()), 32'h0);

        // R6: load mode, payload CAS 3 at bit 4, burst 0
        push(2'b10, 3'b000, 13'h030, 1'b1, -1);
        run_cmd(32'h6014, 3, "R6");

        // R8: precharge both banks, write during busy ignored
        push(2'b00, 3'b010, 13'h400, 1'b1, -1);
        send(32'h1A);
        chk(stat_rdata == 32'h20, "R4", "status while busy", stat_rdata, 32'h20);
        cmd_wr = 1'b1; cmd_wdata = 32'h1B;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_wdata = '0;
        busy_len(n);
        chk(n + 1 == 4, "R8", "busy not lengthened", 32'(n + 1), 32'h4);
        repeat (10) @(negedge clk);
        chk(n_unexp == 0 && q.size() == 0, "R8", "no command from ignored write",
            32'(n_unexp), 32'h0);

        // R3: precharge with no target bits, no chip select, full wait
        run_cmd(32'h02, 4, "R3");
        chk(n_unexp == 0, "R3", "no chip select without target", 32'(n_unexp), 32'h0);

        // R10: normal mode bank 1, refresh every 41 cycles
        push(2'b10, 3'b001, 13'h0, 1'b1, -1);
        push(2'b10, 3'b001, 13'h0, 1'b1, 41);
        push(2'b10, 3'b001, 13'h0, 1'b1, 41);
        run_cmd(32'h10, 4, "R4");
        repeat (128) @(negedge clk);
        chk(q.size() == 0, "R10", "periodic refreshes seen", 32'(q.size()), 32'h0);

        // R2/R7: self-refresh bank 1, CKE low with the command
        push(2'b10, 3'b001, 13'h0, 1'b0, -1);
        run_cmd(32'h15, 5, "R4");
        chk(sd_cke == 1'b0, "R7", "cke after self-refresh", 32'(sd_cke), 32'h0);
        repeat (100) @(negedge clk);
        chk(n_unexp == 0, "R10", "no refresh with banks disabled", 32'(n_unexp), 32'h0);

        // R11: normal both banks, software burst overlaps an expiry
        run_cmd(32'h18, 4, "R7");
        chk(sd_cke == 1'b1, "R7", "cke after normal", 32'(sd_cke), 32'h1);
        push(2'b00, 3'b001, 13'h0, 1'b1, -1);
        push(2'b00, 3'b001, 13'h0, 1'b1, 6);
        push(2'b00, 3'b001, 13'h0, 1'b1, 7);   // R11 deferred refresh
        push(2'b00, 3'b001, 13'h0, 1'b1, 31);  // R10 next periodic refresh
        repeat (32) @(negedge clk);
        run_cmd(32'h3B, 12, "R5");
        repeat (45) @(negedge clk);
        chk(q.size() == 0, "R11", "deferred and periodic refreshes", 32'(q.size()), 32'h0);

        // R7: power-down both banks, CKE low, refresh stops
        run_cmd(32'h1E, 1, "R4");
        chk(sd_cke == 1'b0, "R7", "cke after power-down", 32'(sd_cke), 32'h0);
        repeat (100) @(negedge clk);
        chk(n_unexp == 0 && q.size() == 0, "R10", "no refresh after power-down",
            32'(n_unexp), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule